// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This unit keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. One offset is measured from the empty boundary and one from the full boundary. Both are presented continuously on their own output buses so the flag comparators can use them.

The programming method is fixed by a load-select input that is sampled while master reset is asserted. Sampling high selects a bit-serial shift path, which is gated by a shift enable. Sampling low selects a word-wide path with write and read strobes. The method chosen also sets the values both offsets take out of reset. Only the word-wide path can return the current offsets, and it does so on a registered read-back bus. Requests on the interface that was not selected leave all state unchanged.

Top module: `ofs_prog`

## Requirements
- R1: `load_sel` is captured only on a clock edge where `rst` is high: 1 selects serial mode and 0 selects parallel mode. Later changes of `load_sel` while `rst` is low have no effect until the next reset.
- R2: After a reset in serial mode, both `empty_ofs` and `full_ofs` equal 0x3FF (all ones at the default width of 10). `par_dout` equals 0.
- R3: After a reset in parallel mode, both offsets equal 0x07F (the lowest W-3 bits set). `par_dout` equals 0. The write and read alternations both restart at the empty offset.
- R4: In parallel mode, each clock with `par_wr` high loads `par_din[W-1:0]` into one offset, visible after that edge. The target alternates empty, full, empty, and so on. Bits of `par_din` above W-1 are ignored.
- R5: In parallel mode, each clock with `par_rd` high places the zero-extended value of one offset on `par_dout` after that edge, alternating empty, full, empty, and so on. This alternation is independent of the write alternation. `par_dout` holds its value in cycles without a read.
- R6: When `par_wr` and `par_rd` are high in the same cycle, the read returns the offset value from before that cycle's write.
- R7: In serial mode, each clock with `ser_en` high shifts the 2W-bit chain {full_ofs, empty_ofs} right by one. `ser_in` enters at `full_ofs[W-1]` and `full_ofs[0]` moves into `empty_ofs[W-1]`. After 2W enabled bits, `empty_ofs` holds the first W bits, least significant first, and `full_ofs` holds the next W bits.
- R8: In serial mode, `par_wr`, `par_rd` and `par_din` have no effect on either offset or on `par_dout`.
- R9: In parallel mode, `ser_en` and `ser_in` have no effect on either offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| load_sel | input | 1 | Load method, sampled during reset (1 = serial, 0 = parallel) |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| par_wr | input | 1 | Parallel offset write strobe |
| par_rd | input | 1 | Parallel offset read-back strobe |
| par_din | input | BUS_W (18) | Parallel write data; low W bits are used |
| par_dout | output | BUS_W (18) | Registered read-back data |
| empty_ofs | output | W (10) | Offset from the empty boundary |
| full_ofs | output | W (10) | Offset from the full boundary |

## Verification
A wrong latched mode shows up on the first edge after reset. The offsets leave reset at the other default, and the wrong interface then moves them. A stuck or shared alternation bit shows up on the second write or read after reset, when the wrong offset changes or is returned. A mis-wired serial chain shows up one enabled shift later as a bit appearing in the wrong position of `full_ofs` or `empty_ofs`. The bench compares all three output buses against a reference model after every clock, so each of these faults is reported within the cycle that exposes it.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    typedef enum logic {
        LD_PARALLEL = 1'b0,
        LD_SERIAL   = 1'b1
    } ld_mode_e;

    // strobes produced by the word-wide sequencer for the offset registers
    typedef struct packed {
        logic wr_empty;
        logic wr_full;
    } par_wr_t;

    // reset default for an offset of width w under a given load method
    function automatic logic [31:0] ofs_default(ld_mode_e m, int unsigned w);
        logic [31:0] one;
        one = 32'd1;
        if (m == LD_SERIAL) begin
            return (one << w) - one;
        end
        return (one << (w - 3)) - one;
    endfunction

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch
    import ofs_prog_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_sel,
    output ld_mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= load_sel ? LD_SERIAL : LD_PARALLEL;
        end
    end

endmodule

// File: rtl/ofs_ser_chain.sv
module ofs_ser_chain #(
    parameter int unsigned OFS_W = 10
) (
    input  logic [OFS_W-1:0] cur_empty,
    input  logic [OFS_W-1:0] cur_full,
    input  logic             ser_in,
    output logic [OFS_W-1:0] nxt_empty,
    output logic [OFS_W-1:0] nxt_full
);

    localparam int unsigned CHAIN_W = 2 * OFS_W;

    logic [CHAIN_W-1:0] cur_chain;
    logic [CHAIN_W-1:0] nxt_chain;

    assign cur_chain = {cur_full, cur_empty};

    for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
        if (i == CHAIN_W - 1) begin : g_head
            assign nxt_chain[i] = ser_in;
        end else begin : g_body
            assign nxt_chain[i] = cur_chain[i+1];
        end
    end

    assign nxt_empty = nxt_chain[OFS_W-1:0];
    assign nxt_full  = nxt_chain[CHAIN_W-1:OFS_W];

endmodule

// File: rtl/ofs_par_seq.sv
module ofs_par_seq
    import ofs_prog_pkg::*;
#(
    parameter int unsigned OFS_W = 10,
    parameter int unsigned BUS_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             par_wr,
    input  logic             par_rd,
    input  logic [OFS_W-1:0] cur_empty,
    input  logic [OFS_W-1:0] cur_full,
    output par_wr_t          wr_ctl,
    output logic [BUS_W-1:0] par_dout
);

    logic wr_to_full;
    logic rd_from_full;

    always_comb begin
        wr_ctl.wr_empty = enable && par_wr && !wr_to_full;
        wr_ctl.wr_full  = enable && par_wr &&  wr_to_full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_to_full   <= 1'b0;
            rd_from_full <= 1'b0;
            par_dout     <= '0;
        end else if (enable) begin
            if (par_wr) begin
                wr_to_full <= !wr_to_full;
            end
            if (par_rd) begin
                rd_from_full <= !rd_from_full;
                par_dout     <= BUS_W'(rd_from_full ? cur_full : cur_empty);
            end
        end
    end

endmodule

// File: rtl/ofs_prog.sv
module ofs_prog
    import ofs_prog_pkg::*;
#(
    parameter int unsigned OFS_W = 10,
    parameter int unsigned BUS_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_sel,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic             par_wr,
    input  logic             par_rd,
    input  logic [BUS_W-1:0] par_din,
    output logic [BUS_W-1:0] par_dout,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);

    localparam logic [OFS_W-1:0] DEF_SER = OFS_W'(ofs_default(LD_SERIAL, OFS_W));
    localparam logic [OFS_W-1:0] DEF_PAR = OFS_W'(ofs_default(LD_PARALLEL, OFS_W));

    ld_mode_e         mode;
    par_wr_t          wr_ctl;
    logic [OFS_W-1:0] sh_empty;
    logic [OFS_W-1:0] sh_full;
    logic [OFS_W-1:0] wr_word;
    logic             shift_go;

    ofs_mode_latch u_mode (
        .clk      (clk),
        .rst      (rst),
        .load_sel (load_sel),
        .mode     (mode)
    );

    ofs_ser_chain #(.OFS_W(OFS_W)) u_chain (
        .cur_empty (empty_ofs),
        .cur_full  (full_ofs),
        .ser_in    (ser_in),
        .nxt_empty (sh_empty),
        .nxt_full  (sh_full)
    );

    ofs_par_seq #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_par (
        .clk       (clk),
        .rst       (rst),
        .enable    (mode == LD_PARALLEL),
        .par_wr    (par_wr),
        .par_rd    (par_rd),
        .cur_empty (empty_ofs),
        .cur_full  (full_ofs),
        .wr_ctl    (wr_ctl),
        .par_dout  (par_dout)
    );

    assign wr_word  = par_din[OFS_W-1:0];
    assign shift_go = (mode == LD_SERIAL) && ser_en;

    if (BUS_W > OFS_W) begin : g_hi
        logic unused_din_hi;
        assign unused_din_hi = ^par_din[BUS_W-1:OFS_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_ofs <= load_sel ? DEF_SER : DEF_PAR;
            full_ofs  <= load_sel ? DEF_SER : DEF_PAR;
        end else if (shift_go) begin
            empty_ofs <= sh_empty;
            full_ofs  <= sh_full;
        end else begin
            if (wr_ctl.wr_empty) begin
                empty_ofs <= wr_word;
            end
            if (wr_ctl.wr_full) begin
                full_ofs <= wr_word;
            end
        end
    end

endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
    parameter int unsigned OFS_W = 10,
    parameter int unsigned BUS_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             load_sel,
    input logic             ser_en,
    input logic             ser_in,
    input logic             par_wr,
    input logic             par_rd,
    input logic [BUS_W-1:0] par_dout,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs
);

    logic [OFS_W-1:0] ser_def;
    logic [OFS_W-1:0] par_def;
    logic             is_ser;

    assign ser_def = '1;
    assign par_def = OFS_W'((32'd1 << (OFS_W - 3)) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_ser <= load_sel;
        end
    end

    AST_SER_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && $past(load_sel)) |-> (empty_ofs == ser_def && full_ofs == ser_def && par_dout == '0)); // R2

    AST_PAR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(load_sel)) |-> (empty_ofs == par_def && full_ofs == par_def && par_dout == '0)); // R3

    AST_SER_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (is_ser && ser_en) |=> (full_ofs[OFS_W-1] == $past(ser_in) && empty_ofs[OFS_W-1] == $past(full_ofs[0]))); // R7

    AST_SER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_ser && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs))); // R8

    AST_SER_NO_READBACK: assert property (@(posedge clk) disable iff (rst)
        is_ser |=> $stable(par_dout)); // R8

    AST_PAR_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!is_ser && !par_wr) |=> ($stable(empty_ofs) && $stable(full_ofs))); // R9

    AST_PAR_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (!is_ser && par_wr) |=> ($stable(empty_ofs) || $stable(full_ofs))); // R4

    AST_PAR_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!is_ser && !par_rd) |=> $stable(par_dout)); // R5

endmodule

bind ofs_prog ofs_prog_chk #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_sel  (load_sel),
    .ser_en    (ser_en),
    .ser_in    (ser_in),
    .par_wr    (par_wr),
    .par_rd    (par_rd),
    .par_dout  (par_dout),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
);

// File: tb/ofs_prog_test.sv
module ofs_prog_test;

    localparam int unsigned W  = 10;
    localparam int unsigned BW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_sel = 1'b1;
    logic          ser_en = 1'b0;
    logic          ser_in = 1'b0;
    logic          par_wr = 1'b0;
    logic          par_rd = 1'b0;
    logic [BW-1:0] par_din = '0;
    logic [BW-1:0] par_dout;
    logic [W-1:0]  empty_ofs;
    logic [W-1:0]  full_ofs;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic          m_ser;
    logic [W-1:0]  m_e, m_f;
    logic [BW-1:0] m_dout;
    logic          m_wsel, m_rsel;

    always #10 clk = ~clk;

    ofs_prog #(.OFS_W(W), .BUS_W(BW)) uut (
        .clk(clk), .rst(rst), .load_sel(load_sel), .ser_en(ser_en), .ser_in(ser_in),
        .par_wr(par_wr), .par_rd(par_rd), .par_din(par_din), .par_dout(par_dout),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    function automatic logic [W-1:0] dflt(logic ser);
        return ser ? W'((1 << W) - 1) : W'((1 << (W - 3)) - 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [2*W-1:0] ch;
        if (rst) begin
            m_ser = load_sel; m_e = dflt(load_sel); m_f = dflt(load_sel);
            m_dout = '0; m_wsel = 1'b0; m_rsel = 1'b0;
        end else if (m_ser) begin
            if (ser_en) begin
                ch = {ser_in, m_f, m_e[W-1:1]};
                m_e = ch[W-1:0]; m_f = ch[2*W-1:W];
            end
        end else begin
            if (par_rd) begin
                m_dout = BW'(m_rsel ? m_f : m_e);
                m_rsel = !m_rsel;
            end
            if (par_wr) begin
                if (m_wsel) m_f = par_din[W-1:0]; else m_e = par_din[W-1:0];
                m_wsel = !m_wsel;
            end
        end
    endtask

    // drive inputs, clock once, compare all outputs against the model
    task automatic step(string tag, logic r, logic ls, logic se, logic si,
                        logic pw, logic pr, logic [BW-1:0] pd);
        rst = r; load_sel = ls; ser_en = se; ser_in = si;
        par_wr = pw; par_rd = pr; par_din = pd;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, 32'(empty_ofs), 32'(m_e));
        chk(tag, 32'(full_ofs), 32'(m_f));
        chk(tag, 32'(par_dout), 32'(m_dout));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [2*W-1:0] pat;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        @(negedge clk);

        // R1 R2: reset in serial mode
        step("R2", 1, 1, 0, 0, 0, 0, '0);
        chk("R2", 32'(empty_ofs), 32'h3FF);
        chk("R2", 32'(full_ofs), 32'h3FF);

        // R7: full serial load, empty=0x2A5 then full=0x13C, LSB first
        pat = {10'h13C, 10'h2A5};
        for (int i = 0; i < 2 * W; i++) step("R7", 0, 1, 1, pat[i], 0, 0, '0);
        chk("R7", 32'(empty_ofs), 32'h2A5);
        chk("R7", 32'(full_ofs), 32'h13C);

        // R8: parallel strobes ignored in serial mode
        step("R8", 0, 1, 0, 0, 1, 1, 18'h3FFFF);
        step("R8", 0, 1, 0, 1, 1, 0, 18'h00001);
        chk("R8", 32'(empty_ofs), 32'h2A5);
        chk("R8", 32'(par_dout), 32'h0);

        // R1: load_sel low without reset leaves serial mode
        step("R1", 0, 0, 1, 1, 1, 0, 18'h00055);
        step("R1", 0, 0, 0, 0, 1, 1, 18'h00055);

        // R3: reset in parallel mode
        step("R3", 1, 0, 0, 0, 0, 0, '0);
        chk("R3", 32'(empty_ofs), 32'h07F);
        chk("R3", 32'(full_ofs), 32'h07F);

        // R9: shift requests ignored in parallel mode
        step("R9", 0, 0, 1, 1, 0, 0, '0);
        step("R9", 0, 1, 1, 0, 0, 0, '0);

        // R4: alternation with wrap, upper data bits dropped
        step("R4", 0, 0, 0, 0, 1, 0, 18'h3F123);
        chk("R4", 32'(empty_ofs), 32'h123);
        step("R4", 0, 0, 0, 0, 1, 0, 18'h0C2AA);
        chk("R4", 32'(full_ofs), 32'h2AA);
        step("R4", 0, 0, 0, 0, 1, 0, 18'h00011);
        chk("R4", 32'(empty_ofs), 32'h011);

        // R5: read-back alternation independent of the write side
        step("R5", 0, 0, 0, 0, 0, 1, '0);
        chk("R5", 32'(par_dout), 32'h011);
        step("R5", 0, 0, 0, 0, 0, 0, '0);
        step("R5", 0, 0, 0, 0, 0, 1, '0);
        chk("R5", 32'(par_dout), 32'h2AA);

        // R6: simultaneous write (to full) and read (of empty), then of full
        step("R6", 0, 0, 0, 0, 1, 1, 18'h00333);
        chk("R6", 32'(par_dout), 32'h011);
        step("R6", 0, 0, 0, 0, 1, 1, 18'h00044);
        chk("R6", 32'(par_dout), 32'h333);

        // mixed random traffic in both modes with occasional resets
        for (int n = 0; n < 1500; n++) begin
            logic r;
            r = ($urandom % 60) == 0;
            step(m_ser ? "R7" : "R4", r, 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), BW'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule